// File: doc/BRIEF.md
# Completion Interrupt Controller

This block gathers the end-of-measurement events of a small set of pulse-width channels, together with the arrival of a frame trigger, and folds them into one interrupt request line. Each channel raises a one-cycle done strobe when its measured input pulse ends. The strobe sets a sticky completion flag. The flag stays set until software clears it by writing a one to its bit, or until the next frame trigger starts a new measurement cycle. The frame trigger also sets a flag of its own.

Software chooses the completion rule. It can interrupt when every channel that is not masked has finished, or when at least one unmasked channel has finished. Any channel can be left out of the rule through its mask bit. A separate enable lets the frame-trigger flag raise the interrupt as well. The interrupt is a level: it holds while its condition holds.

For each channel the block also outputs a registered idle indication, plus an all-idle output that combines them. This mirrors how open-drain busy lines behave when they are wired together.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `status` is all zeros, and every bit of `ch_idle` and `all_idle` is 1.
- R2: A one-cycle pulse on `ch_done[i]` sets `status[i]` at the clock edge that samples the pulse, and the bit stays set with no further stimulus.
- R3: A cycle with `clr_we` high clears each `status` bit whose `clr_data` bit is 1. Bits whose `clr_data` bit is 0 keep their value.
- R4: A `frame_trig` pulse clears `status[NUM_CH-1:0]` and sets `status[NUM_CH]`, which is the frame flag.
- R5: A set beats a clear in the same cycle. A channel's done strobe keeps its flag set even when that flag is also being written with a one or cleared by a frame trigger.
- R6: With `mode_all`=0 (any), `irq` rises one cycle after at least one unmasked channel flag is set.
- R7: With `mode_all`=1 (all), `irq` stays 0 while any unmasked channel flag is clear. It rises one cycle after the last unmasked flag is set.
- R8: A channel whose `ch_mask` bit is 1 has no effect on the completion condition, but its `status` bit still records its done strobe.
- R9: When every `ch_mask` bit is 1, the completion condition never raises `irq` in either mode.
- R10: With `frame_irq_en`=1, a set frame flag raises `irq` one cycle later. With `frame_irq_en`=0, the frame flag does not drive `irq`.
- R11: `irq` is a level. It stays 1 while a source condition holds and returns to 0 one cycle after every source condition is gone.
- R12: `ch_idle[i]` is the inverse of `ch_busy[i]`, registered with one cycle of delay. `all_idle` is 1 exactly when every registered `ch_idle` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_busy | input | NUM_CH | Per-channel measurement-in-progress level |
| ch_done | input | NUM_CH | Per-channel one-cycle end-of-pulse strobe |
| frame_trig | input | 1 | One-cycle frame trigger strobe |
| ch_mask | input | NUM_CH | 1 excludes the channel from the completion rule |
| mode_all | input | 1 | 0 = any unmasked channel done, 1 = all unmasked channels done |
| frame_irq_en | input | 1 | Lets the frame flag raise the interrupt |
| clr_we | input | 1 | Write strobe for the write-one-to-clear of the status |
| clr_data | input | NUM_CH+1 | Bits to clear; bit NUM_CH is the frame flag |
| irq | output | 1 | Interrupt request level |
| status | output | NUM_CH+1 | Channel completion flags, with the frame flag in the top bit |
| ch_idle | output | NUM_CH | Registered inverse of each busy level |
| all_idle | output | 1 | 1 when every channel is idle |

## Verification
A done strobe can arrive in the same cycle as a software clear of the same flag, or in the same cycle as a frame trigger that clears all channel flags. The bench drives each collision on a single clock edge. It then reads `status` at the next falling edge, expecting the struck channel's flag to survive while the other channel flags are cleared. It also checks that the interrupt follows that surviving flag one cycle later.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int MAX_CH = 31;

   typedef enum logic {
      COND_ANY = 1'b0,
      COND_ALL = 1'b1
   } cond_mode_e;
endpackage

// File: rtl/cic_flag_bank.sv
module cic_flag_bank #(
   parameter int NUM_CH = 3,
   localparam int SW = NUM_CH + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_ch,
   input  logic              frame_trig,
   input  logic              clr_we,
   input  logic [SW-1:0]     clr_data,
   output logic [SW-1:0]     flags_q
);
   logic [SW-1:0] set_v;
   logic [SW-1:0] clr_v;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign set_v[i] = set_ch[i];
         assign clr_v[i] = (clr_we & clr_data[i]) | frame_trig;

         // a set in the same cycle wins over any clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags_q[i] <= 1'b0;
            else if (set_v[i])  flags_q[i] <= 1'b1;
            else if (clr_v[i])  flags_q[i] <= 1'b0;
         end

         a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_ch[i] |=> flags_q[i]);
         a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[i] && !set_ch[i]) |=> !flags_q[i]);
         a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (!frame_trig && !set_ch[i] && !(clr_we && clr_data[i])) |=> $stable(flags_q[i]));
         a_r4_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_trig && !set_ch[i]) |=> !flags_q[i]);
      end
   endgenerate

   assign set_v[NUM_CH] = frame_trig;
   assign clr_v[NUM_CH] = clr_we & clr_data[NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flags_q[NUM_CH] <= 1'b0;
      else if (set_v[NUM_CH])  flags_q[NUM_CH] <= 1'b1;
      else if (clr_v[NUM_CH])  flags_q[NUM_CH] <= 1'b0;
   end

   a_r4_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
      frame_trig |=> flags_q[NUM_CH]);
endmodule

// File: rtl/cic_cond_eval.sv
module cic_cond_eval #(
   parameter int NUM_CH = 3
) (
   input  logic [NUM_CH-1:0] ch_flags,
   input  logic [NUM_CH-1:0] ch_mask,
   input  logic              mode_all,
   input  logic              frame_flag,
   input  logic              frame_irq_en,
   output logic              comp_hit,
   output logic              frame_hit
);
   import cic_pkg::*;

   cond_mode_e    mode;
   logic [NUM_CH-1:0] unmasked;
   logic [NUM_CH-1:0] finished;
   logic              any_hit;
   logic              all_hit;
   logic              none_enabled;

   always_comb begin
      mode         = cond_mode_e'(mode_all);
      unmasked     = ~ch_mask;
      finished     = ch_flags & unmasked;
      none_enabled = (unmasked == '0);
      any_hit      = |finished;
      all_hit      = !none_enabled && (finished == unmasked);
      unique case (mode)
         COND_ANY: comp_hit = any_hit;
         COND_ALL: comp_hit = all_hit;
         default:  comp_hit = 1'b0;
      endcase
      frame_hit = frame_flag & frame_irq_en;
   end
endmodule

// File: rtl/cic_busy_merge.sv
module cic_busy_merge #(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_busy,
   output logic [NUM_CH-1:0] ch_idle,
   output logic              all_idle
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_idle  <= '1;
         all_idle <= 1'b1;
      end else begin
         ch_idle  <= ~ch_busy;
         all_idle <= ~(|ch_busy);
      end
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         a_r12_busy_seen: assert property (@(posedge clk) disable iff (!rst_n)
            ch_busy[i] |=> !ch_idle[i]);
      end
   endgenerate

   a_r12_and_matches: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle == (&ch_idle));
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl #(
   parameter int NUM_CH        = 3,
   parameter bit IRQ_REGISTERED = 1'b1,
   localparam int SW = NUM_CH + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_busy,
   input  logic [NUM_CH-1:0] ch_done,
   input  logic              frame_trig,
   input  logic [NUM_CH-1:0] ch_mask,
   input  logic              mode_all,
   input  logic              frame_irq_en,
   input  logic              clr_we,
   input  logic [SW-1:0]     clr_data,
   output logic              irq,
   output logic [SW-1:0]     status,
   output logic [NUM_CH-1:0] ch_idle,
   output logic              all_idle
);
   generate
      if (NUM_CH < 1 || NUM_CH > cic_pkg::MAX_CH) begin : g_bad_width
         $error("cmpl_irq_ctrl: NUM_CH out of range");
      end
   endgenerate

   logic [SW-1:0] flags_q;
   logic          comp_hit;
   logic          frame_hit;

   cic_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_ch     (ch_done),
      .frame_trig (frame_trig),
      .clr_we     (clr_we),
      .clr_data   (clr_data),
      .flags_q    (flags_q)
   );

   cic_cond_eval #(.NUM_CH(NUM_CH)) u_cond (
      .ch_flags     (flags_q[NUM_CH-1:0]),
      .ch_mask      (ch_mask),
      .mode_all     (mode_all),
      .frame_flag   (flags_q[NUM_CH]),
      .frame_irq_en (frame_irq_en),
      .comp_hit     (comp_hit),
      .frame_hit    (frame_hit)
   );

   cic_busy_merge #(.NUM_CH(NUM_CH)) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_busy  (ch_busy),
      .ch_idle  (ch_idle),
      .all_idle (all_idle)
   );

   assign status = flags_q;

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= comp_hit | frame_hit;
         end

         a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            ((&ch_mask) && !(frame_irq_en && status[NUM_CH])) |=> !irq);
         a_r10_frame_raises: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_irq_en && status[NUM_CH]) |=> irq);
         a_r11_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (!comp_hit && !frame_hit) |=> !irq);
         a_r6_any_raises: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_all && |(status[NUM_CH-1:0] & ~ch_mask)) |=> irq);
      end else begin : g_irq_comb
         assign irq = comp_hit | frame_hit;
      end
   endgenerate
endmodule

// File: tb/cmpl_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cmpl_irq_ctrl_tb;
   localparam int N  = 3;
   localparam int SW = N + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  ch_busy = '0;
   logic [N-1:0]  ch_done = '0;
   logic          frame_trig = 1'b0;
   logic [N-1:0]  ch_mask = '0;
   logic          mode_all = 1'b0;
   logic          frame_irq_en = 1'b0;
   logic          clr_we = 1'b0;
   logic [SW-1:0] clr_data = '0;
   logic          irq;
   logic [SW-1:0] status;
   logic [N-1:0]  ch_idle;
   logic          all_idle;

   int n_run = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   cmpl_irq_ctrl #(.NUM_CH(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .ch_busy(ch_busy), .ch_done(ch_done),
      .frame_trig(frame_trig), .ch_mask(ch_mask), .mode_all(mode_all),
      .frame_irq_en(frame_irq_en), .clr_we(clr_we), .clr_data(clr_data),
      .irq(irq), .status(status), .ch_idle(ch_idle), .all_idle(all_idle)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic pulse_done(logic [N-1:0] v);
      ch_done = v; step(); ch_done = '0;
   endtask

   task automatic wr_clr(logic [SW-1:0] v);
      clr_we = 1'b1; clr_data = v; step(); clr_we = 1'b0; clr_data = '0;
   endtask

   task automatic t_reset;
      chk("R1 irq", irq, 0);
      chk("R1 status", status, 0);
      chk("R1 ch_idle", ch_idle, 3'b111);
      chk("R1 all_idle", all_idle, 1);
   endtask

   task automatic t_set_hold;
      ch_mask = 3'b111;
      pulse_done(3'b010);
      chk("R2 set", status, 4'b0010);
      step(4);
      chk("R2 hold", status, 4'b0010);
      wr_clr(4'b1111);
   endtask

   task automatic t_w1c;
      pulse_done(3'b101);
      wr_clr(4'b0001);
      chk("R3 clear bit0", status, 4'b0100);
      wr_clr(4'b0000);
      chk("R3 zero write keeps", status, 4'b0100);
      wr_clr(4'b1111);
      chk("R3 clear all", status, 4'b0000);
   endtask

   task automatic t_any;
      ch_mask = 3'b000; mode_all = 1'b0; step();
      pulse_done(3'b100);
      chk("R6 irq lags flag", irq, 0);
      step();
      chk("R6 any raises", irq, 1);
      step(3);
      chk("R11 irq held", irq, 1);
      wr_clr(4'b0100);
      chk("R11 irq one more cycle", irq, 1);
      step();
      chk("R11 irq drops", irq, 0);
   endtask

   task automatic t_all;
      mode_all = 1'b1; step();
      pulse_done(3'b001);
      pulse_done(3'b010);
      step(2);
      chk("R7 partial no irq", irq, 0);
      pulse_done(3'b100);
      step();
      chk("R7 all raises", irq, 1);
      wr_clr(4'b1111); step();
      chk("R7 cleared", irq, 0);
   endtask

   task automatic t_mask;
      mode_all = 1'b1; ch_mask = 3'b100; step();
      pulse_done(3'b011);
      step();
      chk("R8 masked ch2 ignored in all", irq, 1);
      wr_clr(4'b1111); step();
      mode_all = 1'b0; ch_mask = 3'b010; step();
      pulse_done(3'b010);
      step(2);
      chk("R8 status still records", status, 4'b0010);
      chk("R8 masked ch1 no irq", irq, 0);
      wr_clr(4'b1111);
   endtask

   task automatic t_all_masked;
      ch_mask = 3'b111; mode_all = 1'b1; step();
      pulse_done(3'b111);
      step(2);
      chk("R9 all mode quiet", irq, 0);
      mode_all = 1'b0; step(2);
      chk("R9 any mode quiet", irq, 0);
      wr_clr(4'b1111);
   endtask

   task automatic t_frame;
      ch_mask = 3'b111; frame_irq_en = 1'b0;
      pulse_done(3'b111);
      frame_trig = 1'b1; step(); frame_trig = 1'b0;
      chk("R4 frame clears and sets", status, 4'b1000);
      step(2);
      chk("R10 disabled frame no irq", irq, 0);
      frame_irq_en = 1'b1; step();
      chk("R10 enabled frame irq", irq, 1);
      wr_clr(4'b1000); step();
      chk("R10 frame cleared irq off", irq, 0);
      frame_irq_en = 1'b0;
   endtask

   task automatic t_collide;
      ch_mask = 3'b000; mode_all = 1'b0;
      pulse_done(3'b010);
      ch_done = 3'b010; clr_we = 1'b1; clr_data = 4'b0010; step();
      ch_done = '0; clr_we = 1'b0; clr_data = '0;
      chk("R5 set beats w1c", status, 4'b0010);
      pulse_done(3'b100);
      ch_done = 3'b001; frame_trig = 1'b1; step();
      ch_done = '0; frame_trig = 1'b0;
      chk("R5 set beats frame clear", status, 4'b1001);
      step();
      chk("R5 irq follows survivor", irq, 1);
      wr_clr(4'b1111);
   endtask

   task automatic t_idle;
      ch_busy = 3'b010; step();
      chk("R12 idle bits", ch_idle, 3'b101);
      chk("R12 all_idle low", all_idle, 0);
      ch_busy = 3'b000; step();
      chk("R12 idle restored", ch_idle, 3'b111);
      chk("R12 all_idle high", all_idle, 1);
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done_flag) break;
      end
      if (!done_flag) begin
         n_run++; n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      step(2);
      t_reset();
      rst_n = 1'b1;
      step();
      t_set_hold();
      t_w1c();
      t_any();
      t_all();
      t_mask();
      t_all_masked();
      t_frame();
      t_collide();
      t_idle();
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule